// File: doc/BRIEF.md
# ADC Autoscan Conversion Sequencer

This block steps a multi-channel analog-to-digital converter through a scan of input channels. Software programs one 8-bit control byte that sets the first channel of the scan, whether the converter is powered, whether scans repeat, which hardware triggers may start a scan, and a run bit. Each scan converts channels in ascending order, from the programmed first channel through channel 7.

For every channel the sequencer asserts a one-cycle conversion-start strobe and shows the channel number. The converter answers with a done strobe, and the sequencer then moves to the next channel. A scan can start in three ways: software sets the run bit, the active-low external pin falls, or a timer pulses the on-chip event input. Each hardware source counts only when its own enable bit is set.

In single mode, hardware clears the run bit when the scan ends. In continuous mode, scans repeat until software stops them. Any register write cancels the scan in progress, and scanning restarts from the newly written settings.

Top module: `adc_seq`

## Requirements
- R1: After reset the control byte reads 00h, `busy_o` and `conv_start_o` are low, and no conversion is requested.
- R2: A write stores the byte, and it reads back on the next cycle. Field positions are: bit 0 run, bit 1 continuous, bit 2 power-up, bit 3 internal event enable, bit 4 external pin enable, bits 7:5 first channel.
- R3: A scan issues one `conv_start_o` pulse per channel. The first channel is the programmed one, and each later channel is one higher. The next pulse comes the cycle after the previous channel's `conv_done_i`. `conv_ch_o` shows the channel while its pulse is high.
- R4: With first channel 7, a scan converts channel 7 only.
- R5: The done strobe for channel 7 ends the scan, and `busy_o` drops on the next cycle. In single mode the run bit reads 0 from that cycle on.
- R6: In continuous mode a new scan from the first channel begins without any trigger, and the run bit stays 1.
- R7: With bit 4 set, a falling edge on `ext_trig_ni` sets the run bit and starts a scan. The pin passes through a two-stage synchronizer, and a valid low pulse lasts at least one clock.
- R8: With bit 3 set, a one-cycle pulse on `evt_i` sets the run bit and starts a scan.
- R9: A trigger is ignored when its enable bit is 0, while a scan is busy, or while bit 2 is 0.
- R10: A register write aborts the scan in progress, so `busy_o` is low the next cycle. Writing run=0 stops scanning. Writing run=1 restarts the scan from the new first channel.
- R11: While bit 2 is 0, no conversion starts, even with the run bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Control byte write strobe |
| reg_wdata_i | input | 8 | Control byte write data |
| reg_rdata_o | output | 8 | Current control byte |
| ext_trig_ni | input | 1 | External trigger pin, active low, asynchronous |
| evt_i | input | 1 | On-chip timer event pulse |
| conv_start_o | output | 1 | One-cycle conversion start |
| conv_ch_o | output | 3 | Channel being converted |
| conv_done_i | input | 1 | Converter done strobe |
| conv_pwr_o | output | 1 | Power enable to converter |
| busy_o | output | 1 | Scan in progress |

## Verification
A wrong channel counter shows up on `conv_ch_o` at the very next start pulse, as a skipped, repeated or wrapped channel. A wrong end-of-scan decision shows up one cycle after the channel 7 done strobe: either `busy_o` stays high, or the run bit read back has the wrong value. A missed abort leaves `busy_o` high in the cycle after a write. A trigger that should have been ignored produces a stray start pulse within a few cycles, and that pulse can be seen at the ports.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
  localparam int CH_W   = 3;
  localparam int NUM_CH = 1 << CH_W;

  typedef struct packed {
    logic [CH_W-1:0] first_ch;
    logic            ext_en;
    logic            evt_en;
    logic            pwr;
    logic            cont;
    logic            run;
  } ctrl_t;
endpackage

// File: rtl/adc_seq_trig.sv
module adc_seq_trig #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ext_ni,
  input  logic evt_i,
  input  logic ext_en_i,
  input  logic evt_en_i,
  input  logic arm_i,
  output logic trig_o
);
  logic [SYNC_STAGES-1:0] sync_q;
  logic                   prev_q;
  logic                   pin_s;
  logic                   ext_fall;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= ext_ni;
      end
    end else begin : g_chain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) sync_q <= '1;
        else         sync_q <= {sync_q[SYNC_STAGES-2:0], ext_ni};
      end
    end
  endgenerate

  assign pin_s = sync_q[SYNC_STAGES-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= 1'b1;
    else         prev_q <= pin_s;
  end

  assign ext_fall = prev_q & ~pin_s;
  assign trig_o   = arm_i & ((ext_fall & ext_en_i) | (evt_i & evt_en_i));
endmodule

// File: rtl/adc_seq_ctrl_reg.sv
module adc_seq_ctrl_reg
  import adc_seq_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] wdata_i,
  input  logic       trig_i,
  input  logic       seq_end_i,
  output ctrl_t      ctrl_o
);
  ctrl_t ctrl_q;

  // software write wins over hardware set/clear of the run bit
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (we_i) begin
      ctrl_q <= ctrl_t'(wdata_i);
    end else begin
      if (trig_i)                     ctrl_q.run <= 1'b1;
      if (seq_end_i && !ctrl_q.cont)  ctrl_q.run <= 1'b0;
    end
  end

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/adc_seq_fsm.sv
module adc_seq_fsm
  import adc_seq_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            abort_i,
  input  logic            run_i,
  input  logic            pwr_i,
  input  logic [CH_W-1:0] first_ch_i,
  input  logic            done_i,
  output logic            busy_o,
  output logic [CH_W-1:0] ch_o,
  output logic            start_o,
  output logic            seq_end_o
);
  localparam logic [CH_W-1:0] LAST_CH = '1;

  logic            busy_q;
  logic            start_q;
  logic [CH_W-1:0] ch_q;
  logic            launch;
  logic            last;

  assign launch    = !busy_q && run_i && pwr_i && !abort_i;
  assign last      = (ch_q == LAST_CH);
  assign seq_end_o = busy_q && done_i && last && !abort_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
      ch_q    <= '0;
    end else if (abort_i) begin
      busy_q  <= 1'b0;
      start_q <= 1'b0;
    end else if (launch) begin
      busy_q  <= 1'b1;
      start_q <= 1'b1;
      ch_q    <= first_ch_i;
    end else if (busy_q && done_i) begin
      if (last) begin
        busy_q  <= 1'b0;
        start_q <= 1'b0;
      end else begin
        ch_q    <= ch_q + 1'b1;
        start_q <= 1'b1;
      end
    end else begin
      start_q <= 1'b0;
    end
  end

  assign busy_o  = busy_q;
  assign ch_o    = ch_q;
  assign start_o = start_q;
endmodule

// File: rtl/adc_seq.sv
module adc_seq
  import adc_seq_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       reg_we_i,
  input  logic [7:0] reg_wdata_i,
  output logic [7:0] reg_rdata_o,
  input  logic       ext_trig_ni,
  input  logic       evt_i,
  output logic       conv_start_o,
  output logic [2:0] conv_ch_o,
  input  logic       conv_done_i,
  output logic       conv_pwr_o,
  output logic       busy_o
);
  ctrl_t ctrl;
  logic  trig;
  logic  seq_end;
  logic  busy;

  adc_seq_trig #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ext_ni   (ext_trig_ni),
    .evt_i    (evt_i),
    .ext_en_i (ctrl.ext_en),
    .evt_en_i (ctrl.evt_en),
    .arm_i    (ctrl.pwr && !busy),
    .trig_o   (trig)
  );

  adc_seq_ctrl_reg u_reg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .we_i      (reg_we_i),
    .wdata_i   (reg_wdata_i),
    .trig_i    (trig),
    .seq_end_i (seq_end),
    .ctrl_o    (ctrl)
  );

  adc_seq_fsm u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .abort_i    (reg_we_i),
    .run_i      (ctrl.run),
    .pwr_i      (ctrl.pwr),
    .first_ch_i (ctrl.first_ch),
    .done_i     (conv_done_i),
    .busy_o     (busy),
    .ch_o       (conv_ch_o),
    .start_o    (conv_start_o),
    .seq_end_o  (seq_end)
  );

  assign reg_rdata_o = ctrl;
  assign conv_pwr_o  = ctrl.pwr;
  assign busy_o      = busy;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       reg_we_i,
  input logic [7:0] reg_wdata_i,
  input logic [7:0] reg_rdata_o,
  input logic       conv_done_i,
  input logic       conv_start_o,
  input logic [2:0] conv_ch_o,
  input logic       busy_o
);
  p_start_in_scan_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> busy_o);

  p_first_ch_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_o) |-> conv_start_o && conv_ch_o == reg_rdata_o[7:5]);

  p_ch_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && conv_done_i && conv_ch_o != 3'd7 && !reg_we_i
    |=> conv_start_o && conv_ch_o == $past(conv_ch_o) + 3'd1);

  p_single_end_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o && conv_done_i && conv_ch_o == 3'd7 && !reg_we_i && !reg_rdata_o[1]
    |=> !busy_o && !reg_rdata_o[0]);

  p_wr_store_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> reg_rdata_o == $past(reg_wdata_i));

  p_abort_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_i |=> !busy_o && !conv_start_o);

  p_pwr_off_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_rdata_o[2] |-> !busy_o);
endmodule

bind adc_seq adc_seq_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .reg_we_i     (reg_we_i),
  .reg_wdata_i  (reg_wdata_i),
  .reg_rdata_o  (reg_rdata_o),
  .conv_done_i  (conv_done_i),
  .conv_start_o (conv_start_o),
  .conv_ch_o    (conv_ch_o),
  .busy_o       (busy_o)
);

// File: tb/adc_seq_tb.sv
`timescale 1ns/1ps
module adc_seq_tb;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       reg_we_i = 1'b0;
  logic [7:0] reg_wdata_i = '0;
  logic [7:0] reg_rdata_o;
  logic       ext_trig_ni = 1'b1;
  logic       evt_i = 1'b0;
  logic       conv_start_o;
  logic [2:0] conv_ch_o;
  logic       conv_done_i = 1'b0;
  logic       conv_pwr_o;
  logic       busy_o;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #4 clk_i = ~clk_i;

  adc_seq u_dut (.*);

  // {wdata, expected conversions, expected run bit after}
  localparam logic [15:0] VEC [6] = '{
    {8'h05, 4'd8, 4'd0},
    {8'h65, 4'd5, 4'd0},
    {8'hE5, 4'd1, 4'd0},
    {8'hA5, 4'd3, 4'd0},
    {8'h01, 4'd0, 4'd1},
    {8'h25, 4'd7, 4'd0}
  };

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] d);
    @(negedge clk_i);
    reg_we_i = 1'b1;
    reg_wdata_i = d;
    @(negedge clk_i);
    reg_we_i = 1'b0;
  endtask

  // converter model: answers each start with done, checks channel order
  task automatic scan(input int first, output int n);
    int idle = 0;
    n = 0;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk_i);
      conv_done_i = 1'b0;
      if (conv_start_o) begin
        chk(int'(conv_ch_o) == first + n, "R3 channel order", conv_ch_o, first + n);
        n++;
        conv_done_i = 1'b1;
      end else if (!busy_o) begin
        if (n > 0) break;
        idle++;
        if (idle > 20) break;
      end
    end
    conv_done_i = 1'b0;
  endtask

  task automatic evt_pulse();
    @(negedge clk_i);
    evt_i = 1'b1;
    @(negedge clk_i);
    evt_i = 1'b0;
  endtask

  task automatic pin_pulse();
    @(negedge clk_i);
    ext_trig_ni = 1'b0;
    repeat (3) @(negedge clk_i);
    ext_trig_ni = 1'b1;
  endtask

  task automatic quiet(input int cycles, input string req);
    int starts = 0;
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk_i);
      if (conv_start_o) starts++;
    end
    chk(starts == 0, req, starts, 0);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk_i);
    chk(reg_rdata_o == 8'h00 && !busy_o && !conv_start_o, "R1 reset state",
        {busy_o, conv_start_o, reg_rdata_o}, 0);
    rst_ni = 1'b1;
    quiet(5, "R1 idle after reset");

    for (int i = 0; i < 6; i++) begin
      wr(VEC[i][15:8]);
      chk(reg_rdata_o == VEC[i][15:8], "R2 readback", reg_rdata_o, VEC[i][15:8]);
      scan(int'(VEC[i][15:13]), n);
      chk(n == int'(VEC[i][7:4]), "R3 R4 R11 conversion count", n, VEC[i][7:4]);
      chk(reg_rdata_o[0] == VEC[i][0], "R5 run bit after scan", reg_rdata_o[0], VEC[i][0]);
      chk(!busy_o, "R5 busy low after scan", busy_o, 0);
    end

    // continuous mode repeats
    wr(8'h47);
    scan(2, n);
    chk(n == 6, "R6 first scan count", n, 6);
    chk(reg_rdata_o[0], "R6 run bit kept", reg_rdata_o[0], 1);
    scan(2, n);
    chk(n == 6, "R6 repeat scan count", n, 6);

    // abort and restart
    wr(8'h05);
    @(negedge clk_i);
    chk(conv_start_o && conv_ch_o == 3'd0, "R10 scan started", conv_ch_o, 0);
    wr(8'hC5);
    chk(!busy_o, "R10 abort clears busy", busy_o, 0);
    scan(6, n);
    chk(n == 2, "R10 restart from new channel", n, 2);

    // software stop in continuous mode
    wr(8'h07);
    @(negedge clk_i);
    wr(8'h06);
    chk(!busy_o, "R10 stop clears busy", busy_o, 0);
    quiet(10, "R10 no start after stop");

    // external pin trigger
    wr(8'h14);
    pin_pulse();
    scan(0, n);
    chk(n == 8, "R7 pin scan count", n, 8);
    chk(!reg_rdata_o[0], "R7 run cleared after single scan", reg_rdata_o[0], 0);

    // pin trigger with enable off
    wr(8'h04);
    pin_pulse();
    scan(0, n);
    chk(n == 0, "R9 disabled pin ignored", n, 0);
    chk(reg_rdata_o == 8'h04, "R9 run bit untouched", reg_rdata_o, 8'h04);

    // internal event trigger
    wr(8'h6C);
    evt_pulse();
    scan(3, n);
    chk(n == 5, "R8 event scan count", n, 5);

    // event during busy, coinciding with last done
    wr(8'hEC);
    evt_pulse();
    @(negedge clk_i);
    chk(conv_start_o && conv_ch_o == 3'd7, "R4 only channel 7", conv_ch_o, 7);
    evt_i = 1'b1;
    conv_done_i = 1'b1;
    @(negedge clk_i);
    evt_i = 1'b0;
    conv_done_i = 1'b0;
    chk(!busy_o && !reg_rdata_o[0], "R9 event while busy ignored",
        {busy_o, reg_rdata_o[0]}, 0);
    quiet(10, "R9 no scan from busy event");

    // power down blocks triggers
    wr(8'h18);
    evt_pulse();
    pin_pulse();
    quiet(10, "R11 no start when powered down");
    chk(reg_rdata_o == 8'h18, "R9 triggers ignored when powered down", reg_rdata_o, 8'h18);
    chk(!conv_pwr_o, "R11 power output low", conv_pwr_o, 0);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule